// File: doc/BRIEF.md
# Radio-State-Driven Output Pin Controller

This block drives four general-purpose output pins for a radio front end, typically used for antenna or transmit/receive switches and external amplifier enables. A small register file, written over a simple address/data port, selects one of two operating modes. In manual mode, software-written levels go straight to the pins. In automatic mode, the pins follow the state of an external radio enable state machine, which is reported to the block as alert, receive or transmit.

In automatic mode, all pins sit at a programmed rest pattern while the state machine is in alert. On entry to receive or transmit, a per-state mask selects which pins invert. Each pin can hold back its inversion by its own number of microseconds. A shared prescaler divides the reference clock down to a one-microsecond tick. The delays are honoured only when the state machine is steered from its enable pins; when it is steered over the serial bus, the inversions happen at once. A frequency-division-duplex flag suppresses all receive-side behaviour. A return to alert cancels any inversion that is still pending.

Top module: `gpo_toggle_ctrl`

## Requirements
- R1: After reset, all registers hold zero, automatic mode is selected and `gpo` reads 0.
- R2: When bit 4 of the mode register (address 0x0) is 1, pin i drives bit 4+i of the level register (address 0x1). The pin changes on the clock edge after the edge that accepts the write.
- R3: In manual mode, bits 3:0 of the mode register, the mask register, the delays and the radio state have no effect on `gpo`.
- R4: In automatic mode, while the state input is alert (code 0, and code 3 is treated as alert), pin i equals bit i of the level register. A write to that register shows on `gpo` one edge after the write edge.
- R5: The mask register (address 0x2) selects the pins that invert. Bit 4+i inverts pin i on entry to receive (code 1), and bit i inverts pin i on entry to transmit (code 2). Inverted levels are relative to the rest pattern, including on a direct change between receive and transmit.
- R6: With a rest pattern of all ones and a mask of 0x24, `gpo` is 0xF in alert, 0xB in transmit and 0xD in receive.
- R7: With the control-source input high, a pin selected for inversion changes at edge E1 + D·(P+1). Here E1 is the first edge that samples the new state, D is the pin's 8-bit delay (receive delay for pin i at address 0x4+i, transmit delay at 0x8+i), and P is bits 6:0 of the prescale register (address 0x3).
- R8: A delay of zero inverts the pin at E1.
- R9: With the control-source input low (serial-bus control), every selected pin inverts at E1, whatever its delay.
- R10: With the duplex flag high, entry to receive leaves all pins at the rest pattern, while the transmit mask and transmit delays still apply.
- R11: A change back to alert returns every pin to the rest pattern at E1 and cancels pending inversions, so none occurs afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| ensm_state | input | 2 | Radio state: 0 alert, 1 receive, 2 transmit |
| pin_ctrl | input | 1 | 1: state machine driven from its enable pins (delays honoured) |
| fdd_mode | input | 1 | Frequency-division-duplex flag |
| gpo | output | 4 | Registered output pin levels |

## Verification
Every result comes out of the `gpo` register, so each result is due at a fixed edge. A register write is captured at one edge and shows on `gpo` at the next. A state change shows at E1, the first edge that samples it. A delayed inversion shows exactly D·(P+1) edges after E1. The bench drives inputs and samples outputs one nanosecond after a rising edge. It counts edges from the stimulus and compares `gpo` to a value it computes from the rest pattern, the masks and these edge counts. For the delay cases, it checks every edge of the window, so an inversion that comes one edge early or one edge late is reported.

// File: rtl/gpo_pkg.sv
package gpo_pkg;

  typedef enum logic [1:0] {
    ST_ALERT = 2'd0,
    ST_RX    = 2'd1,
    ST_TX    = 2'd2
  } radio_state_e;

  localparam int unsigned ADDR_MODE     = 0;
  localparam int unsigned ADDR_LEVEL    = 1;
  localparam int unsigned ADDR_MASK     = 2;
  localparam int unsigned ADDR_PRESC    = 3;
  localparam int unsigned ADDR_RXD_BASE = 4;
  localparam int unsigned ADDR_TXD_BASE = 8;
  localparam int unsigned MANUAL_BIT    = 4;
  localparam int unsigned NIBBLE        = 4;

endpackage

// File: rtl/gpo_regfile.sv
module gpo_regfile
  import gpo_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DLY_W    = 8,
  parameter int unsigned PRE_W    = 7
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic                               manual_o,
  output logic [NUM_PINS-1:0]                lvl_man_o,
  output logic [NUM_PINS-1:0]                lvl_init_o,
  output logic [NUM_PINS-1:0]                rx_mask_o,
  output logic [NUM_PINS-1:0]                tx_mask_o,
  output logic [PRE_W-1:0]                   presc_o,
  output logic [NUM_PINS-1:0][DLY_W-1:0]     rx_dly_o,
  output logic [NUM_PINS-1:0][DLY_W-1:0]     tx_dly_o
);

  logic              manual_q;
  logic [DATA_W-1:0] level_q;
  logic [DATA_W-1:0] mask_q;
  logic [PRE_W-1:0]  presc_q;

  logic hit_mode, hit_level, hit_mask, hit_presc;

  assign hit_mode  = wr_en && (wr_addr == ADDR_W'(ADDR_MODE));
  assign hit_level = wr_en && (wr_addr == ADDR_W'(ADDR_LEVEL));
  assign hit_mask  = wr_en && (wr_addr == ADDR_W'(ADDR_MASK));
  assign hit_presc = wr_en && (wr_addr == ADDR_W'(ADDR_PRESC));

  // Only the mode bit is stored; the other mode bits have no function.
  always_ff @(posedge clk) begin
    if (rst) begin
      manual_q <= 1'b0;
      level_q  <= '0;
      mask_q   <= '0;
      presc_q  <= '0;
    end else begin
      if (hit_mode)  manual_q <= wr_data[MANUAL_BIT];
      if (hit_level) level_q  <= wr_data;
      if (hit_mask)  mask_q   <= wr_data;
      if (hit_presc) presc_q  <= wr_data[PRE_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_dly
    logic [DLY_W-1:0] rxd_q, txd_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        rxd_q <= '0;
        txd_q <= '0;
      end else begin
        if (wr_en && (wr_addr == ADDR_W'(ADDR_RXD_BASE + i))) rxd_q <= wr_data[DLY_W-1:0];
        if (wr_en && (wr_addr == ADDR_W'(ADDR_TXD_BASE + i))) txd_q <= wr_data[DLY_W-1:0];
      end
    end
    assign rx_dly_o[i] = rxd_q;
    assign tx_dly_o[i] = txd_q;
  end

  assign manual_o   = manual_q;
  assign lvl_man_o  = level_q[NIBBLE +: NUM_PINS];
  assign lvl_init_o = level_q[0 +: NUM_PINS];
  assign rx_mask_o  = mask_q[NIBBLE +: NUM_PINS];
  assign tx_mask_o  = mask_q[0 +: NUM_PINS];
  assign presc_o    = presc_q;

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> (!manual_q && level_q == '0));

endmodule

// File: rtl/gpo_tick_gen.sv
module gpo_tick_gen #(
  parameter int unsigned PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);

  logic [PRE_W-1:0] cnt_q;

  // ">=" keeps the period bounded if the limit is lowered mid-count.
  assign tick = (cnt_q >= presc);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + PRE_W'(1);
  end

  // R7
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && !tick) |=> (cnt_q == $past(cnt_q) + PRE_W'(1)));

  // R7
  restart_align_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/gpo_pin_timer.sv
module gpo_pin_timer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             start,
  input  logic             bypass,
  input  logic [DLY_W-1:0] dly,
  input  logic             tick,
  output logic             act_nxt_o,
  output logic             act_o
);

  logic [DLY_W-1:0] cnt_q, cnt_n;
  logic             act_q, act_n;

  always_comb begin
    cnt_n = cnt_q;
    act_n = act_q;
    if (evt) begin
      act_n = 1'b0;
      cnt_n = '0;
      if (start) begin
        if (bypass || dly == '0) act_n = 1'b1;
        else                     cnt_n = dly;
      end
    end else if (tick && cnt_q != '0) begin
      cnt_n = cnt_q - DLY_W'(1);
      if (cnt_q == DLY_W'(1)) act_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      act_q <= act_n;
    end
  end

  assign act_nxt_o = act_n;
  assign act_o     = act_q;

  // R7
  no_early_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> !act_q);

  // R8
  zero_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && start && (bypass || dly == '0)) |=> act_q);

  // R11
  cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && !start) |=> (!act_q && cnt_q == '0));

endmodule

// File: rtl/gpo_toggle_ctrl.sv
module gpo_toggle_ctrl
  import gpo_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DLY_W    = 8,
  parameter int unsigned PRE_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [1:0]          ensm_state,
  input  logic                pin_ctrl,
  input  logic                fdd_mode,
  output logic [NUM_PINS-1:0] gpo
);

  localparam int unsigned MASK_HI = NIBBLE + NUM_PINS;

  logic                           manual;
  logic [NUM_PINS-1:0]            lvl_man, lvl_init, rx_mask, tx_mask;
  logic [PRE_W-1:0]               presc;
  logic [NUM_PINS-1:0][DLY_W-1:0] rx_dly, tx_dly;

  radio_state_e st_cur, st_q;
  logic         evt, enter_rx, enter_tx, tick;
  logic [NUM_PINS-1:0] act_n, act_q, start;
  logic [NUM_PINS-1:0] gpo_q, gpo_d;

  gpo_regfile #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .DLY_W(DLY_W), .PRE_W(PRE_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .manual_o(manual), .lvl_man_o(lvl_man), .lvl_init_o(lvl_init),
    .rx_mask_o(rx_mask), .tx_mask_o(tx_mask), .presc_o(presc),
    .rx_dly_o(rx_dly), .tx_dly_o(tx_dly)
  );

  // Unknown state code is folded onto alert.
  always_comb begin
    case (ensm_state)
      2'd1:    st_cur = ST_RX;
      2'd2:    st_cur = ST_TX;
      default: st_cur = ST_ALERT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_ALERT;
    else     st_q <= st_cur;
  end

  assign evt      = (st_cur != st_q);
  assign enter_rx = evt && (st_cur == ST_RX) && !fdd_mode;
  assign enter_tx = evt && (st_cur == ST_TX);

  gpo_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst(rst), .restart(evt), .presc(presc), .tick(tick)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [DLY_W-1:0] dly_sel;
    assign start[i] = (enter_rx && rx_mask[i]) || (enter_tx && tx_mask[i]);
    assign dly_sel  = enter_tx ? tx_dly[i] : rx_dly[i];

    gpo_pin_timer #(.DLY_W(DLY_W)) u_pin (
      .clk(clk), .rst(rst), .evt(evt), .start(start[i]), .bypass(!pin_ctrl),
      .dly(dly_sel), .tick(tick), .act_nxt_o(act_n[i]), .act_o(act_q[i])
    );
  end

  assign gpo_d = manual ? lvl_man : (lvl_init ^ act_n);

  always_ff @(posedge clk) begin
    if (rst) gpo_q <= '0;
    else     gpo_q <= gpo_d;
  end

  assign gpo = gpo_q;

  initial begin
    if (NUM_PINS > NIBBLE || MASK_HI > DATA_W || DLY_W > DATA_W)
      $error("gpo_toggle_ctrl: unsupported parameter set");
  end

  // R2
  manual_level_chk: assert property (@(posedge clk) disable iff (rst)
    manual |=> (gpo == $past(lvl_man)));

  // R4
  alert_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (!manual && st_cur == ST_ALERT) |=> (gpo == $past(lvl_init)));

  // R10
  fdd_rx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fdd_mode && evt && st_cur == ST_RX) |=> (act_q == '0));

  // R5
  one_state_chk: assert property (@(posedge clk) disable iff (rst)
    (evt && st_cur == ST_TX) |-> ((start & ~tx_mask) == '0));

endmodule

// File: tb/tb_gpo_toggle_ctrl.sv
module tb_gpo_toggle_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] ensm_state = 2'd0;
  logic       pin_ctrl = 1'b1;
  logic       fdd_mode = 1'b0;
  logic [3:0] gpo;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpo_toggle_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ensm_state(ensm_state), .pin_ctrl(pin_ctrl), .fdd_mode(fdd_mode), .gpo(gpo)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [3:0] exp, input string tag);
    n_chk++;
    if (gpo !== exp) begin
      n_fail++;
      $display("FAIL %s: gpo=%h expected %h", tag, gpo, exp);
    end
  endtask

  function automatic logic [3:0] due(input logic [3:0] base, input logic [3:0] msk,
                                     input int d[4], input int per, input int k);
    logic [3:0] r = base;
    for (int i = 0; i < 4; i++)
      if (msk[i] && k >= d[i] * per) r[i] = ~r[i];
    return r;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    int dtx[4];
    int drx[4];
    step(2);
    rst = 1'b0;

    // R1: reset state, automatic mode
    chk(4'h0, "R1");
    wr(4'h1, 8'hA5);
    step(1);
    chk(4'h5, "R1");

    // R5/R4: sweep of rest pattern and masks
    for (int init = 0; init < 16; init++) begin
      for (int m = 0; m < 256; m += 5) begin
        wr(4'h1, 8'(init));
        wr(4'h2, 8'(m));
        step(1);
        chk(4'(init), "R4");
        ensm_state = 2'd1; step(1);
        chk(4'(init) ^ 4'(m >> 4), "R5");
        ensm_state = 2'd2; step(1);
        chk(4'(init) ^ 4'(m), "R5");
        ensm_state = 2'd3; step(1);
        chk(4'(init), "R4");
        ensm_state = 2'd0; step(1);
      end
    end

    // R6: worked example
    wr(4'h1, 8'hFF); wr(4'h2, 8'h24); step(1);
    chk(4'hF, "R6");
    ensm_state = 2'd2; step(1); chk(4'hB, "R6");
    ensm_state = 2'd0; step(1); chk(4'hF, "R6");
    ensm_state = 2'd1; step(1); chk(4'hD, "R6");
    ensm_state = 2'd0; step(1);

    // R7/R8: per-pin transmit delays, P=2
    dtx = '{0, 1, 2, 3};
    wr(4'h3, 8'h02);
    for (int i = 0; i < 4; i++) wr(4'(8 + i), 8'(dtx[i]));
    wr(4'h1, 8'h00); wr(4'h2, 8'h0F); step(1);
    pin_ctrl = 1'b1;
    ensm_state = 2'd2;
    for (int k = 0; k < 12; k++) begin
      step(1);
      chk(due(4'h0, 4'hF, dtx, 3, k), k == 0 ? "R8" : "R7");
    end
    ensm_state = 2'd0; step(1);

    // R9: serial-bus control ignores delays
    pin_ctrl = 1'b0;
    ensm_state = 2'd2; step(1);
    chk(4'hF, "R9");
    ensm_state = 2'd0; step(1);
    pin_ctrl = 1'b1;

    // R11: cancel pending receive toggles
    drx = '{5, 5, 5, 5};
    for (int i = 0; i < 4; i++) wr(4'(4 + i), 8'(drx[i]));
    wr(4'h1, 8'h05); wr(4'h2, 8'hF0); step(1);
    ensm_state = 2'd1;
    for (int k = 0; k < 5; k++) begin
      step(1);
      chk(4'h5, "R7");
    end
    ensm_state = 2'd0; step(1);
    chk(4'h5, "R11");
    step(25);
    chk(4'h5, "R11");

    // R10: duplex flag suppresses receive, keeps transmit delays
    fdd_mode = 1'b1;
    for (int i = 0; i < 4; i++) wr(4'(4 + i), 8'h00);
    wr(4'h2, 8'hFF); step(1);
    ensm_state = 2'd1; step(1);
    chk(4'h5, "R10");
    step(20);
    chk(4'h5, "R10");
    ensm_state = 2'd0; step(1);
    ensm_state = 2'd2;
    for (int k = 0; k < 12; k++) begin
      step(1);
      chk(due(4'h5, 4'hF, dtx, 3, k), "R10");
    end
    ensm_state = 2'd0; step(1);
    fdd_mode = 1'b0;

    // R2: manual levels
    wr(4'h0, 8'h10);
    for (int v = 0; v < 16; v++) begin
      wr(4'h1, {4'(v), ~4'(v)});
      step(1);
      chk(4'(v), "R2");
    end

    // R3: lower mode bits, masks and state ignored in manual mode
    wr(4'h1, 8'h9C); wr(4'h0, 8'h1F); step(1);
    chk(4'h9, "R3");
    ensm_state = 2'd2; step(1); chk(4'h9, "R3");
    wr(4'h2, 8'h3C); step(1); chk(4'h9, "R3");
    ensm_state = 2'd1; step(10); chk(4'h9, "R3");
    ensm_state = 2'd0; step(1);
    wr(4'h0, 8'h00); step(1);
    chk(4'hC, "R4");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule